// File: doc/BRIEF.md
# Serial NOR Range Erase Sequencer

This block erases an aligned byte range of a serial NOR flash device through a byte-at-a-time SPI transaction port. A request carries a start offset, a length, an addressing-mode flag (three or four address bytes) and a blank-check flag. The range is cut into granules. Each granule is either a large block (64 KiB by default) or a small sector (4 KiB by default): the large one is chosen when the current offset is aligned to it and enough bytes remain. For each granule the sequencer can first read the region back and skip the erase when every 32-bit word reads as all ones. Otherwise it waits for the device to leave its busy state, sets the write-enable latch and confirms it, then sends the erase command. After the last granule it waits once more for the device to go idle, then pulses `done` with a result code.

The state machine has these states. `ST_IDLE` waits for `start`. `ST_PICK` chooses the next granule, or starts the closing wait once nothing remains. `ST_RD_XFER` sends one read-back chunk and `ST_RD_EVAL` judges it. `ST_POLL_CMD`, `ST_POLL_RX` and `ST_POLL_GAP` carry out status polling. `ST_WREN`, `ST_WEL_CMD` and `ST_WEL_RX` set the write-enable latch and verify it. `ST_ERASE` sends the erase command, `ST_ADVANCE` moves the offset and the remaining length forward, and `ST_REPORT` pulses `done`.

The transitions are as follows:
- start (IDLE→PICK, or IDLE→REPORT on an invalid request)
- pick-read (PICK→RD_XFER)
- pick-poll (PICK→POLL_CMD)
- chunk-end (RD_XFER→RD_EVAL)
- next-chunk (RD_EVAL→RD_XFER)
- dirty (RD_EVAL→POLL_CMD)
- skip (RD_EVAL→ADVANCE)
- poll-busy (POLL_RX→POLL_GAP)
- gap-over (POLL_GAP→POLL_CMD)
- ready (POLL_RX→WREN, or POLL_RX→REPORT on the closing wait)
- expire (POLL_RX→REPORT)
- latch-ok (WEL_RX→ERASE)
- latch-bad (WEL_RX→REPORT)
- erased (ERASE→ADVANCE)
- step (ADVANCE→PICK)
- abort (any transfer state→REPORT)
- finish (REPORT→IDLE)

Top module: `nor_erase_seq`

## Requirements
- R1: A request whose offset or length is not a multiple of the small granule (2^SMALL_LOG2 bytes), or whose length is zero, ends with `result` = 1 (invalid) and no byte is requested on the SPI port.
- R2: A granule uses the large size with opcode 0xD8 when the current offset is a multiple of 2^BIG_LOG2 and at least 2^BIG_LOG2 bytes remain. In every other case it uses the small size with opcode 0x20.
- R3: With `blank_chk` set, each granule is read with opcode 0x03 plus address in transactions of CHUNK_BYTES data bytes. Reading stops after the first chunk that holds a 32-bit word other than all ones, and the erase follows. A granule that reads fully blank is not erased and causes no status or write-enable traffic.
- R4: Before each erase, status (opcode 0x05 followed by one byte read) is read until bit 0 (busy) is clear. Successive polls are separated by GAP_CYC idle cycles.
- R5: If MAX_POLLS consecutive polls in one wait all read busy, the operation ends with `result` = 3 (timeout). A clear reading on poll number MAX_POLLS proceeds normally.
- R6: After the busy wait, opcode 0x06 is sent as its own transaction, then status is read. If bit 1 (write-enable latch) is clear, the operation ends with `result` = 2 and no erase is sent.
- R7: The erase command is the opcode followed by the offset, most significant byte first: four bytes when `addr_4b` is 1, otherwise the low three bytes. The command is a single transaction.
- R8: After the last granule, the status is polled until busy is clear before `done` pulses for one cycle with `result` = 0.
- R9: An acknowledged byte with `xfer_err` set ends the operation with `result` = 2. No further byte is requested.
- R10: `xfer_req`, `xfer_byte` and `xfer_last` hold steady until `xfer_ack`. `xfer_last` marks the final byte of each transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a request (accepted in idle) |
| offset | input | AW | Start byte offset |
| length | input | AW | Byte count to erase |
| addr_4b | input | 1 | 1 = four address bytes, 0 = three |
| blank_chk | input | 1 | 1 = read back and skip blank granules |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 invalid, 2 failure, 3 timeout |
| xfer_req | output | 1 | Byte exchange requested |
| xfer_byte | output | 8 | Byte to send |
| xfer_last | output | 1 | Final byte of the transaction |
| xfer_ack | input | 1 | Byte exchanged this cycle |
| xfer_rx | input | 8 | Byte received with the acknowledge |
| xfer_err | input | 1 | Exchange failed (valid with acknowledge) |

## Verification
Two events can fall on the same status reading: the device going idle and the poll limit running out. The bench sets up this clash by holding the modelled device busy for exactly MAX_POLLS−1 readings, and then for MAX_POLLS readings. The first run must proceed to the erase and the second must report a timeout with no erase. A second clash, a dirty word in the last chunk of a granule against the granule's end, is covered by sweeps in which dirty sectors sit at every position inside large and small granules. In those sweeps the number of read transactions must match the count computed in the bench.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;
    localparam logic [7:0] OPC_STATUS  = 8'h05;
    localparam logic [7:0] OPC_WREN    = 8'h06;
    localparam logic [7:0] OPC_ERASE_S = 8'h20;
    localparam logic [7:0] OPC_ERASE_B = 8'hD8;
    localparam logic [7:0] OPC_READ    = 8'h03;
    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_WEL_BIT  = 1;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_INVAL   = 2'd1,
        RES_FAIL    = 2'd2,
        RES_TIMEOUT = 2'd3
    } res_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PICK, ST_RD_XFER, ST_RD_EVAL,
        ST_POLL_CMD, ST_POLL_RX, ST_POLL_GAP,
        ST_WREN, ST_WEL_CMD, ST_WEL_RX,
        ST_ERASE, ST_ADVANCE, ST_REPORT
    } st_e;
endpackage

// File: rtl/nor_granule_pick.sv
module nor_granule_pick #(
    parameter int AW         = 32,
    parameter int SMALL_LOG2 = 12,
    parameter int BIG_LOG2   = 16
) (
    input  logic [AW-1:0] cur_off,
    input  logic [AW-1:0] remain,
    output logic          use_big,
    output logic [AW-1:0] gran_bytes,
    output logic [7:0]    opcode
);
    import nor_erase_pkg::*;
    localparam logic [AW-1:0] SMALL = AW'(1) << SMALL_LOG2;
    localparam logic [AW-1:0] BIG   = AW'(1) << BIG_LOG2;

    always_comb begin
        use_big    = (cur_off[BIG_LOG2-1:0] == '0) && (remain >= BIG);
        gran_bytes = use_big ? BIG : SMALL;
        opcode     = use_big ? OPC_ERASE_B : OPC_ERASE_S;
    end
endmodule

// File: rtl/nor_blank_acc.sv
module nor_blank_acc #(
    parameter int WORD_BYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    output logic       dirty
);
    localparam int CW = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int WW = 8 * WORD_BYTES;

    logic [CW-1:0] pos;
    logic [WW-1:0] word;
    logic [WW-1:0] word_next;

    always_comb word_next = {byte_in, word[WW-1:8]};

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pos   <= '0;
            word  <= '0;
            dirty <= 1'b0;
        end else if (byte_vld) begin
            word <= word_next;
            if (pos == CW'(WORD_BYTES - 1)) begin
                pos <= '0;
                if (word_next != '1) dirty <= 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    // R3: once a non-blank word is seen it stays flagged until cleared
    assert_dirty_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty && !clear) |=> dirty);
endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int MAX_POLLS = 1000,
    parameter int GAP_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic busy_seen,
    input  logic in_gap,
    output logic last_poll,
    output logic gap_done
);
    localparam int PW = $clog2(MAX_POLLS + 1);
    localparam int GW = $clog2(GAP_CYC + 1);

    logic [PW-1:0] polls;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (!rst_n || !active) polls <= '0;
        else if (busy_seen)    polls <= polls + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !in_gap) gap <= '0;
        else                   gap <= gap + 1'b1;
    end

    always_comb begin
        last_poll = (polls == PW'(MAX_POLLS - 1));
        gap_done  = (gap == GW'(GAP_CYC - 1));
    end

    // R5: the busy count in one wait never reaches the limit
    assert_poll_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        polls < PW'(MAX_POLLS));
    // R4: the gap is not left before it has run its length
    assert_gap_span_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_gap && !gap_done) |=> in_gap);
endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq #(
    parameter int AW          = 32,
    parameter int SMALL_LOG2  = 12,
    parameter int BIG_LOG2    = 16,
    parameter int CHUNK_BYTES = 64,
    parameter int MAX_POLLS   = 1000,
    parameter int GAP_CYC     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] length,
    input  logic          addr_4b,
    input  logic          blank_chk,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic          xfer_req,
    output logic [7:0]    xfer_byte,
    output logic          xfer_last,
    input  logic          xfer_ack,
    input  logic [7:0]    xfer_rx,
    input  logic          xfer_err
);
    import nor_erase_pkg::*;

    localparam int            DW    = $clog2(CHUNK_BYTES);
    localparam logic [AW-1:0] CHUNK = AW'(CHUNK_BYTES);

    st_e           state;
    res_e          res_q;
    logic [AW-1:0] cur_off, remain, rd_ptr, gran_left;
    logic          four_b, chk_blank, fin;
    logic [2:0]    bidx;
    logic [DW-1:0] dcnt;
    logic [2:0]    na;

    logic          pk_big;
    logic [AW-1:0] pk_gran;
    logic [7:0]    pk_op;
    logic          dirty, last_poll, gap_done;
    logic          acked, failed, data_phase, rx_busy;

    function automatic logic [7:0] addr_byte(input logic [AW-1:0] a,
                                             input logic [2:0] idx,
                                             input logic [2:0] n);
        logic [5:0]    sh;
        logic [AW-1:0] t;
        sh = {n - idx, 3'b000};
        t  = a >> sh;
        return t[7:0];
    endfunction

    always_comb begin
        na         = four_b ? 3'd4 : 3'd3;
        acked      = xfer_req && xfer_ack && !xfer_err;
        failed     = xfer_req && xfer_ack && xfer_err;
        data_phase = (bidx > na);
        rx_busy    = xfer_rx[STAT_BUSY_BIT];
    end

    nor_granule_pick #(.AW(AW), .SMALL_LOG2(SMALL_LOG2), .BIG_LOG2(BIG_LOG2)) u_pick (
        .cur_off(cur_off), .remain(remain),
        .use_big(pk_big), .gran_bytes(pk_gran), .opcode(pk_op)
    );

    nor_blank_acc #(.WORD_BYTES(4)) u_blank (
        .clk(clk), .rst_n(rst_n),
        .clear(state == ST_PICK),
        .byte_vld(state == ST_RD_XFER && acked && data_phase),
        .byte_in(xfer_rx),
        .dirty(dirty)
    );

    nor_poll_timer #(.MAX_POLLS(MAX_POLLS), .GAP_CYC(GAP_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n),
        .active(state == ST_POLL_CMD || state == ST_POLL_RX || state == ST_POLL_GAP),
        .busy_seen(state == ST_POLL_RX && acked && rx_busy && !last_poll),
        .in_gap(state == ST_POLL_GAP),
        .last_poll(last_poll),
        .gap_done(gap_done)
    );

    // State register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            res_q     <= RES_OK;
            cur_off   <= '0;
            remain    <= '0;
            rd_ptr    <= '0;
            gran_left <= '0;
            four_b    <= 1'b0;
            chk_blank <= 1'b0;
            fin       <= 1'b0;
            bidx      <= '0;
            dcnt      <= '0;
        end else if (failed) begin
            res_q <= RES_FAIL;
            state <= ST_REPORT;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    cur_off   <= offset;
                    remain    <= length;
                    four_b    <= addr_4b;
                    chk_blank <= blank_chk;
                    fin       <= 1'b0;
                    if (offset[SMALL_LOG2-1:0] != '0 || length[SMALL_LOG2-1:0] != '0 ||
                        length == '0) begin
                        res_q <= RES_INVAL;
                        state <= ST_REPORT;
                    end else begin
                        state <= ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (remain == '0) begin
                        fin   <= 1'b1;
                        state <= ST_POLL_CMD;
                    end else begin
                        rd_ptr    <= cur_off;
                        gran_left <= pk_gran;
                        bidx      <= '0;
                        dcnt      <= '0;
                        state     <= chk_blank ? ST_RD_XFER : ST_POLL_CMD;
                    end
                end
                ST_RD_XFER: if (acked) begin
                    if (!data_phase) begin
                        bidx <= bidx + 1'b1;
                    end else if (dcnt == DW'(CHUNK_BYTES - 1)) begin
                        rd_ptr    <= rd_ptr + CHUNK;
                        gran_left <= gran_left - CHUNK;
                        state     <= ST_RD_EVAL;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                ST_RD_EVAL: begin
                    if (dirty) begin
                        state <= ST_POLL_CMD;
                    end else if (gran_left == '0) begin
                        state <= ST_ADVANCE;
                    end else begin
                        bidx  <= '0;
                        dcnt  <= '0;
                        state <= ST_RD_XFER;
                    end
                end
                ST_POLL_CMD: if (acked) state <= ST_POLL_RX;
                ST_POLL_RX: if (acked) begin
                    if (rx_busy) begin
                        if (last_poll) begin
                            res_q <= RES_TIMEOUT;
                            state <= ST_REPORT;
                        end else begin
                            state <= ST_POLL_GAP;
                        end
                    end else if (fin) begin
                        res_q <= RES_OK;
                        state <= ST_REPORT;
                    end else begin
                        state <= ST_WREN;
                    end
                end
                ST_POLL_GAP: if (gap_done) state <= ST_POLL_CMD;
                ST_WREN:     if (acked) state <= ST_WEL_CMD;
                ST_WEL_CMD:  if (acked) state <= ST_WEL_RX;
                ST_WEL_RX: if (acked) begin
                    if (!xfer_rx[STAT_WEL_BIT]) begin
                        res_q <= RES_FAIL;
                        state <= ST_REPORT;
                    end else begin
                        bidx  <= '0;
                        state <= ST_ERASE;
                    end
                end
                ST_ERASE: if (acked) begin
                    if (bidx == na) state <= ST_ADVANCE;
                    else            bidx  <= bidx + 1'b1;
                end
                ST_ADVANCE: begin
                    cur_off <= cur_off + pk_gran;
                    remain  <= remain - pk_gran;
                    state   <= ST_PICK;
                end
                ST_REPORT: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        xfer_req  = 1'b0;
        xfer_byte = 8'h00;
        xfer_last = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_RD_XFER: begin
                xfer_req  = 1'b1;
                xfer_byte = (bidx == 3'd0) ? OPC_READ :
                            (data_phase ? 8'h00 : addr_byte(rd_ptr, bidx, na));
                xfer_last = data_phase && (dcnt == DW'(CHUNK_BYTES - 1));
            end
            ST_POLL_CMD, ST_WEL_CMD: begin
                xfer_req  = 1'b1;
                xfer_byte = OPC_STATUS;
            end
            ST_POLL_RX, ST_WEL_RX: begin
                xfer_req  = 1'b1;
                xfer_last = 1'b1;
            end
            ST_WREN: begin
                xfer_req  = 1'b1;
                xfer_byte = OPC_WREN;
                xfer_last = 1'b1;
            end
            ST_ERASE: begin
                xfer_req  = 1'b1;
                xfer_byte = (bidx == 3'd0) ? pk_op : addr_byte(cur_off, bidx, na);
                xfer_last = (bidx == na);
            end
            ST_REPORT: done = 1'b1;
            default: ;
        endcase
        busy   = (state != ST_IDLE);
        result = res_q;
    end

    // R10: a pending byte stays put until acknowledged
    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_ack) |=> (xfer_req && $stable(xfer_byte) && $stable(xfer_last)));
    // R9: an error response stops all further requests
    assert_err_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && xfer_ack && xfer_err) |=> !xfer_req);
    // R8: completion is a single-cycle pulse with the port quiet
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: a clear write-enable latch reading ends the request without an erase
    assert_wel_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WEL_RX && acked && !xfer_rx[STAT_WEL_BIT]) |=> (done && !xfer_req));
endmodule

// File: tb/sim_nor_erase_seq.sv
module sim_nor_erase_seq;
    localparam int SL = 6, BL = 8, CH = 16, MP = 4, GP = 3;
    localparam int SM = 1 << SL, BG = 1 << BL;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, addr_4b = 1'b0, blank_chk = 1'b0;
    logic [31:0] offset = '0, length = '0;
    logic busy, done, xfer_req, xfer_last;
    logic [1:0] result;
    logic [7:0] xfer_byte;
    logic xfer_ack = 1'b0, xfer_err = 1'b0;
    logic [7:0] xfer_rx = 8'h00;

    always #2.5 clk = ~clk;

    nor_erase_seq #(.AW(32), .SMALL_LOG2(SL), .BIG_LOG2(BL), .CHUNK_BYTES(CH),
                    .MAX_POLLS(MP), .GAP_CYC(GP)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .offset(offset), .length(length),
        .addr_4b(addr_4b), .blank_chk(blank_chk), .busy(busy), .done(done),
        .result(result), .xfer_req(xfer_req), .xfer_byte(xfer_byte),
        .xfer_last(xfer_last), .xfer_ack(xfer_ack), .xfer_rx(xfer_rx), .xfer_err(xfer_err));

    int tests = 0, fails = 0, cyc = 0;

    // flash model state
    bit   m_dirty [64];
    int   m_busy, busy_after, pos, byte_cnt, err_at, n_er, n_reads, n_status, polls_since, bad_er;
    bit   m_wel, refuse;
    logic [7:0]  mop;
    logic [31:0] m_addr;
    int   m_na;
    logic [7:0]  rec_op [64];
    logic [31:0] rec_addr [64];
    int   rec_len [64];

    task automatic model_reset(input int init_busy, input int b_after, input int e_at,
                               input bit ref_wel, input bit four);
        m_busy = init_busy; busy_after = b_after; err_at = e_at; refuse = ref_wel;
        m_na = four ? 4 : 3; pos = 0; byte_cnt = 0; n_er = 0; n_reads = 0;
        n_status = 0; polls_since = 0; bad_er = 0; m_wel = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_ack = 1'b0; xfer_err = 1'b0;
        end else if (xfer_ack) begin
            xfer_ack = 1'b0; xfer_err = 1'b0;
        end else if (xfer_req) begin
            logic [7:0] rxv;
            logic [31:0] a;
            rxv = 8'h00;
            if (pos == 0) begin mop = xfer_byte; m_addr = '0; end
            if (pos >= 1 && pos <= m_na) m_addr = {m_addr[23:0], xfer_byte};
            if (mop == 8'h05 && pos == 1) begin
                rxv = {6'b0, m_wel, (m_busy > 0)};
                if (m_busy > 0) m_busy--;
                n_status++; polls_since++;
            end
            if (mop == 8'h03 && pos > m_na) begin
                a = m_addr + 32'(pos - m_na - 1);
                rxv = (m_dirty[(a >> 6) & 63] && ((a & 63) == 63)) ? 8'h00 : 8'hFF;
            end
            byte_cnt++;
            xfer_err = (byte_cnt == err_at);
            xfer_rx  = rxv;
            xfer_ack = 1'b1;
            if (xfer_last) begin
                if (mop == 8'h06 && !refuse) m_wel = 1'b1;
                if (mop == 8'h03) n_reads++;
                if (mop == 8'h20 || mop == 8'hD8) begin
                    if (!m_wel) bad_er++;
                    rec_op[n_er & 63] = mop; rec_addr[n_er & 63] = m_addr;
                    rec_len[n_er & 63] = pos + 1; n_er++;
                    m_wel = 1'b0; m_busy = busy_after; polls_since = 0;
                end
                pos = 0;
            end else begin
                pos++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] off, input logic [31:0] len, input bit four, input bit blank);
        @(negedge clk);
        offset = off; length = len; addr_4b = four; blank_chk = blank; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic sweep_one(input int u, input int n, input bit four, input bit blank);
        logic [31:0] base, o, r, ea;
        int e, er, g, dk, st_exp;
        bit big;
        base = four ? 32'h1200_0000 : 32'h5603_0000;
        model_reset(0, 1, -1, 1'b0, four);
        run(base + 32'(u * SM), 32'(n * SM), four, blank);
        chk(result == 2'd0, "R8 result ok", result, 0);
        chk(m_busy == 0, "R8 idle before done", m_busy, 0);
        o = base + 32'(u * SM); r = 32'(n * SM); e = 0; er = 0;
        while (r > 0) begin
            big = (o % BG == 0) && (r >= BG);
            g = big ? BG : SM;
            dk = -1;
            for (int k = 0; k < g / SM; k++)
                if (dk < 0 && m_dirty[((o >> 6) + 32'(k)) & 63]) dk = k;
            if (blank) er += (dk < 0) ? g / CH : (dk + 1) * (SM / CH);
            if (!blank || dk >= 0) begin
                ea = four ? o : {8'h00, o[23:0]};
                chk(rec_op[e & 63] == (big ? 8'hD8 : 8'h20), "R2 opcode", rec_op[e & 63], big ? 8'hD8 : 8'h20);
                chk(rec_addr[e & 63] == ea, "R7 address", rec_addr[e & 63], ea);
                chk(rec_len[e & 63] == m_na + 1, "R7 length", rec_len[e & 63], m_na + 1);
                e++;
            end
            o += 32'(g); r -= 32'(g);
        end
        chk(n_er == e, "R3 erase count", n_er, e);
        chk(bad_er == 0, "R6 latch set at erase", bad_er, 0);
        if (blank) chk(n_reads == er, "R3 read chunks", n_reads, er);
        st_exp = (e == 0) ? 1 : 3 * e + 1;
        chk(n_status == st_exp, "R4 status reads", n_status, st_exp);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) m_dirty[i] = (i % 3 == 1);
        model_reset(0, 0, -1, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && xfer_req == 0, "reset outputs quiet", {busy, done, xfer_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: invalid requests
        model_reset(0, 0, -1, 1'b0, 1'b0);
        run(32'h0000_0020, 32'(SM), 1'b0, 1'b0);
        chk(result == 2'd1, "R1 misaligned offset", result, 1);
        run(32'h0000_0040, 32'h0, 1'b0, 1'b0);
        chk(result == 2'd1, "R1 zero length", result, 1);
        run(32'h0000_0040, 32'(SM / 2), 1'b1, 1'b0);
        chk(result == 2'd1, "R1 short length", result, 1);
        run(32'h0000_0000, 32'(SM + 8), 1'b1, 1'b1);
        chk(result == 2'd1, "R1 ragged length", result, 1);
        chk(byte_cnt == 0, "R1 no bytes sent", byte_cnt, 0);

        // R5: busy clears exactly on the last allowed poll
        model_reset(MP - 1, 0, -1, 1'b0, 1'b0);
        run(32'h0000_0000, 32'(SM), 1'b0, 1'b0);
        chk(result == 2'd0, "R5 clear on last poll", result, 0);
        chk(n_er == 1, "R5 erase after last poll", n_er, 1);
        // R5: one more busy reading expires
        model_reset(MP, 0, -1, 1'b0, 1'b0);
        run(32'h0000_0000, 32'(SM), 1'b0, 1'b0);
        chk(result == 2'd3, "R5 timeout", result, 3);
        chk(n_er == 0, "R5 no erase on timeout", n_er, 0);
        chk(n_status == MP, "R5 poll count", n_status, MP);

        // R6: latch refused
        model_reset(0, 0, -1, 1'b1, 1'b1);
        run(32'h0000_0000, 32'(BG), 1'b1, 1'b0);
        chk(result == 2'd2, "R6 latch failure", result, 2);
        chk(n_er == 0, "R6 no erase", n_er, 0);

        // R9: error on third byte (write enable)
        model_reset(0, 0, 3, 1'b0, 1'b0);
        run(32'h0000_0000, 32'(SM), 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        chk(result == 2'd2, "R9 error result", result, 2);
        chk(byte_cnt == 3, "R9 no bytes after error", byte_cnt, 3);
        chk(xfer_req == 0, "R9 port quiet", xfer_req, 0);

        // R8: closing wait sees busy twice
        model_reset(0, 2, -1, 1'b0, 1'b1);
        run(32'h0000_0000, 32'(SM), 1'b1, 1'b0);
        chk(polls_since == 3, "R8 closing polls", polls_since, 3);
        chk(m_busy == 0 && result == 2'd0, "R8 done after idle", m_busy, 0);
        @(negedge clk);
        chk(done == 0, "R8 done single cycle", done, 0);

        // Sweeps: R2 R3 R4 R7 R8
        for (int u = 0; u < 8; u++)
            for (int n = 1; n <= 8; n++)
                sweep_one(u, n, (u + n) % 2 == 1, 1'b0);
        for (int u = 0; u < 8; u += 2)
            for (int n = 1; n <= 5; n += 2)
                sweep_one(u, n, u % 4 == 0, 1'b1);
        sweep_one(4, 4, 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule